// File: doc/BRIEF.md
# Character line expansion scaler

This block is the vertical scaler of a character display generator whose font is 18 scan lines tall. A display row starts with a row-start pulse. On each horizontal sync tick after that the block moves to the next scan line and reports which of the 18 font lines is to be fetched for it. The displayed height comes from a 7-bit height code. The top two bits repeat the whole font one, two or three times. The low five bits add that many extra lines, and these duplicate font lines spread evenly over the font. The height is limited to 71 lines.

Once the character lines are done, the block can append up to 31 blank spacing lines, flagged on a blank output. A double-height flag shows every displayed line on two scan lines. When the last scan line of the row is over, the block pulses row-done and then waits, blanked, for the next row-start. The height code, the spacing and the double-height flag are sampled at row-start and stay fixed for the whole row.

Top module: `lx_line_scaler`

## Requirements
- R1: After reset the block is idle: `blank_o`=1, `font_line_o`=0, `row_done_o`=0.
- R2: Height code bits [6:5] set the base height. `0x` gives 18 lines, `10` gives 36 and `11` gives 54. Bit 5 is ignored when bit 6 is 0.
- R3: Height code bits [4:0] add their binary value in extra lines (weights 16, 8, 4, 2 and 1) to the base height H. For example, code 0x0D gives H = 31.
- R4: The character height H is clamped at 71 lines. For example, code 0x7F gives 71 and not 85.
- R5: Displayed line d (0..H-1) of a row fetches font line floor(d*18/H), so `font_line_o` stays within 0..17 and rises by at most 1 per displayed line.
- R6: With the double-height flag set, each displayed line is held for two scan lines: scan line s shows displayed line floor(s/2), and the character part lasts 2*H scan lines.
- R7: After the character lines, `spacing_i` (0..31) blank scan lines follow, with `blank_o`=1 and `font_line_o`=0.
- R8: `row_done_o` is high for exactly one cycle, the one after the tick that ends the last scan line of the row. After that the block stays idle (`blank_o`=1, `font_line_o`=0) and further ticks are ignored.
- R9: Row-start takes effect on the next cycle and returns the block to scan line 0 (`font_line_o`=0, `blank_o`=0), even in the middle of a row and even when a tick arrives in the same cycle.
- R10: The height code, spacing and double-height flag are sampled only at row-start. Changing them during a row has no effect on that row.
- R11: Outputs change only in the cycle after a tick or a row-start. Without either, they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_tick_i | input | 1 | One-cycle pulse per horizontal line |
| row_start_i | input | 1 | One-cycle pulse that begins a character row |
| height_code_i | input | 7 | Repeat select [6:5] and inserted-line count [4:0] |
| spacing_i | input | 5 | Blank spacing lines after the row |
| dbl_height_i | input | 1 | Show each displayed line twice |
| font_line_o | output | 5 | Font line to fetch for the current scan line |
| blank_o | output | 1 | Current scan line is spacing or idle |
| row_done_o | output | 1 | One-cycle pulse when the row is finished |

## Verification
A wrong accumulator remainder or a wrong line counter shows up on `font_line_o` within a few ticks, as a repeated or skipped font line. It is caught by comparing every scan line with floor(d*18/H). A wrong height, clamp or spacing count moves the falling edge of the character part and the `row_done_o` pulse by whole ticks, which the per-line comparison over complete rows exposes at the exact tick. Parameters that leak through during a row, or a restart that is not honoured, change the line sequence of the very next tick.

// File: rtl/lx_pkg.sv
package lx_pkg;
  localparam int LX_FONT_LINES = 18;
  localparam int LX_MAX_LINES  = 71;
  localparam int LX_INS_W      = 5;
  localparam int LX_SPACE_W    = 5;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CHAR  = 2'd1,
    PH_SPACE = 2'd2
  } lx_phase_e;
endpackage

// File: rtl/lx_height_calc.sv
module lx_height_calc #(
  parameter int FONT_LINES = 18,
  parameter int MAX_LINES  = 71,
  parameter int INS_W      = 5,
  parameter int LINE_W     = 7
) (
  input  logic [INS_W+1:0]  code_i,
  output logic [LINE_W-1:0] total_o
);
  localparam int SUM_W = $clog2(3*FONT_LINES + (1 << INS_W));
  localparam logic [SUM_W-1:0] BASE1 = SUM_W'(FONT_LINES);
  localparam logic [SUM_W-1:0] BASE2 = SUM_W'(2*FONT_LINES);
  localparam logic [SUM_W-1:0] BASE3 = SUM_W'(3*FONT_LINES);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(MAX_LINES);

  logic [SUM_W-1:0] base, sum;

  always_comb begin
    unique case (code_i[INS_W+1:INS_W])
      2'b10:   base = BASE2;
      2'b11:   base = BASE3;
      default: base = BASE1;
    endcase
    sum     = base + SUM_W'(code_i[INS_W-1:0]);
    total_o = (sum > LIMIT) ? LINE_W'(MAX_LINES) : LINE_W'(sum);
  end
endmodule

// File: rtl/lx_bres_map.sv
module lx_bres_map #(
  parameter int FONT_LINES = 18,
  parameter int LINE_W     = 7,
  parameter int FONT_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [LINE_W-1:0] total_i,
  output logic [FONT_W-1:0] font_o
);
  localparam int ACC_W = LINE_W + 1;

  logic [ACC_W-1:0] acc_q, acc_sum, tot_ext;
  logic [FONT_W-1:0] font_q;

  // acc holds d*FONT_LINES mod total; total >= FONT_LINES so one wrap per step
  assign acc_sum = acc_q + ACC_W'(FONT_LINES);
  assign tot_ext = ACC_W'(total_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      font_q <= '0;
    end else if (clear_i) begin
      acc_q  <= '0;
      font_q <= '0;
    end else if (step_i) begin
      if (acc_sum >= tot_ext) begin
        acc_q  <= acc_sum - tot_ext;
        font_q <= font_q + 1'b1;
      end else begin
        acc_q  <= acc_sum;
      end
    end
  end

  assign font_o = font_q;
endmodule

// File: rtl/lx_row_seq.sv
module lx_row_seq
  import lx_pkg::*;
#(
  parameter int LINE_W  = 7,
  parameter int SPACE_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [LINE_W-1:0]  total_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic               dbl_i,
  output logic               step_o,
  output logic               blank_o,
  output logic               done_o
);
  lx_phase_e          phase_q;
  logic [LINE_W-1:0]  line_q;
  logic [SPACE_W-1:0] sp_q;
  logic               sub_q, done_q;
  logic               last_line, last_sp, hold_sub;

  assign last_line = (line_q == LINE_W'(total_i - 1'b1));
  assign last_sp   = (sp_q == SPACE_W'(space_i - 1'b1));
  assign hold_sub  = dbl_i && !sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      line_q  <= '0;
      sp_q    <= '0;
      sub_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        phase_q <= PH_CHAR;
        line_q  <= '0;
        sp_q    <= '0;
        sub_q   <= 1'b0;
      end else if (tick_i) begin
        unique case (phase_q)
          PH_CHAR: begin
            if (hold_sub) begin
              sub_q <= 1'b1;
            end else begin
              sub_q <= 1'b0;
              if (last_line) begin
                sp_q <= '0;
                if (space_i == '0) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
                end else begin
                  phase_q <= PH_SPACE;
                end
              end else begin
                line_q <= line_q + 1'b1;
              end
            end
          end
          PH_SPACE: begin
            if (last_sp) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              sp_q <= sp_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign step_o  = tick_i && !start_i && (phase_q == PH_CHAR) && !hold_sub && !last_line;
  assign blank_o = (phase_q != PH_CHAR);
  assign done_o  = done_q;
endmodule

// File: rtl/lx_line_scaler.sv
module lx_line_scaler
  import lx_pkg::*;
#(
  parameter int FONT_LINES = LX_FONT_LINES,
  parameter int MAX_LINES  = LX_MAX_LINES,
  parameter int INS_W      = LX_INS_W,
  parameter int SPACE_W    = LX_SPACE_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          hsync_tick_i,
  input  logic                          row_start_i,
  input  logic [INS_W+1:0]              height_code_i,
  input  logic [SPACE_W-1:0]            spacing_i,
  input  logic                          dbl_height_i,
  output logic [$clog2(FONT_LINES)-1:0] font_line_o,
  output logic                          blank_o,
  output logic                          row_done_o
);
  localparam int CODE_W = INS_W + 2;
  localparam int LINE_W = $clog2(MAX_LINES + 1);
  localparam int FONT_W = $clog2(FONT_LINES);

  logic [CODE_W-1:0]  code_q;
  logic [SPACE_W-1:0] space_q;
  logic               dbl_q;
  logic [LINE_W-1:0]  total;
  logic [FONT_W-1:0]  font;
  logic               step, blank;

  // row parameters are frozen at row start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      space_q <= '0;
      dbl_q   <= 1'b0;
    end else if (row_start_i) begin
      code_q  <= height_code_i;
      space_q <= spacing_i;
      dbl_q   <= dbl_height_i;
    end
  end

  lx_height_calc #(
    .FONT_LINES(FONT_LINES), .MAX_LINES(MAX_LINES), .INS_W(INS_W), .LINE_W(LINE_W)
  ) u_height (
    .code_i (code_q),
    .total_o(total)
  );

  lx_row_seq #(.LINE_W(LINE_W), .SPACE_W(SPACE_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (hsync_tick_i),
    .start_i(row_start_i),
    .total_i(total),
    .space_i(space_q),
    .dbl_i  (dbl_q),
    .step_o (step),
    .blank_o(blank),
    .done_o (row_done_o)
  );

  lx_bres_map #(.FONT_LINES(FONT_LINES), .LINE_W(LINE_W), .FONT_W(FONT_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(row_start_i),
    .step_i (step),
    .total_i(total),
    .font_o (font)
  );

  assign blank_o     = blank;
  assign font_line_o = blank ? '0 : font;
endmodule

// File: rtl/lx_scaler_chk.sv
module lx_scaler_chk #(
  parameter int FONT_LINES = 18
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          hsync_tick_i,
  input logic                          row_start_i,
  input logic [$clog2(FONT_LINES)-1:0] font_line_o,
  input logic                          blank_o,
  input logic                          row_done_o
);
  p_font_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    font_line_o <= ($clog2(FONT_LINES))'(FONT_LINES - 1));

  p_font_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_tick_i && !row_start_i && !blank_o) |=>
      (blank_o || font_line_o == $past(font_line_o) ||
       font_line_o == $past(font_line_o) + 1'b1));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_done_o |=> !row_done_o);

  p_done_after_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_done_o) |-> ($past(hsync_tick_i) && !$past(row_start_i)));

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_start_i |=> (font_line_o == '0 && !blank_o && !row_done_o));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsync_tick_i && !row_start_i) |=> ($stable(font_line_o) && $stable(blank_o)));
endmodule

bind lx_line_scaler lx_scaler_chk #(.FONT_LINES(FONT_LINES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsync_tick_i(hsync_tick_i),
  .row_start_i (row_start_i),
  .font_line_o (font_line_o),
  .blank_o     (blank_o),
  .row_done_o  (row_done_o)
);

// File: tb/lx_line_scaler_tb.sv
`timescale 1ns/1ps
module lx_line_scaler_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hsync_tick_i = 1'b0;
  logic       row_start_i = 1'b0;
  logic [6:0] height_code_i = '0;
  logic [4:0] spacing_i = '0;
  logic       dbl_height_i = 1'b0;
  logic [4:0] font_line_o;
  logic       blank_o;
  logic       row_done_o;

  always #4 clk_i = ~clk_i;

  lx_line_scaler u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_tick_i(hsync_tick_i),
    .row_start_i(row_start_i), .height_code_i(height_code_i),
    .spacing_i(spacing_i), .dbl_height_i(dbl_height_i),
    .font_line_o(font_line_o), .blank_o(blank_o), .row_done_o(row_done_o)
  );

  typedef struct {
    int         due;
    logic [4:0] font;
    logic       blank;
    logic       done;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare each expectation in the cycle it falls due
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due != cyc || font_line_o !== e.font || blank_o !== e.blank || row_done_o !== e.done) begin
        failures++;
        $display("FAIL %s cyc=%0d actual font=%0d blank=%0b done=%0b expected font=%0d blank=%0b done=%0b",
                 e.tag, cyc, font_line_o, blank_o, row_done_o, e.font, e.blank, e.done);
      end
    end
  end

  task automatic push(input logic [4:0] f, input logic b, input logic d, input string tag);
    exp_t e;
    e.due = cyc + 1; e.font = f; e.blank = b; e.done = d; e.tag = tag;
    q.push_back(e);
  endtask

  // called at posedge+2; drives one cycle of stimulus
  task automatic drive(input logic tk, input logic rs);
    hsync_tick_i = tk;
    row_start_i  = rs;
    @(posedge clk_i); #2;
    hsync_tick_i = 1'b0;
    row_start_i  = 1'b0;
  endtask

  function automatic int calc_h(input logic [6:0] code);
    int rep, h;
    rep = code[6] ? (code[5] ? 3 : 2) : 1;
    h = 18 * rep + int'(code[4:0]);
    return (h > 71) ? 71 : h;
  endfunction

  task automatic push_line(input int s, input int h, input int m, input string tag);
    if (s < h * m) push(5'((((s / m) * 18) / h)), 1'b0, 1'b0, tag);
    else           push(5'd0, 1'b1, 1'b0, "R7");
  endtask

  task automatic run_row(input logic [6:0] code, input logic [4:0] sp, input logic dbl,
                         input bit scramble, input int stop_after, input logic with_tick,
                         input string tag);
    int h, m, tot;
    string ltag;
    h = calc_h(code);
    m = dbl ? 2 : 1;
    tot = h * m + int'(sp);
    ltag = scramble ? "R10" : tag;
    height_code_i = code; spacing_i = sp; dbl_height_i = dbl;
    push(5'd0, 1'b0, 1'b0, with_tick ? "R9" : tag);
    drive(with_tick, 1'b1);
    if (scramble) begin
      height_code_i = 7'h7F; spacing_i = 5'd9; dbl_height_i = ~dbl;
    end
    for (int s = 1; s < tot; s++) begin
      if (stop_after > 0 && s > stop_after) return;
      if (s % 5 == 0) begin
        push_line(s - 1, h, m, "R11");
        drive(1'b0, 1'b0);
      end
      push_line(s, h, m, ltag);
      drive(1'b1, 1'b0);
    end
    push(5'd0, 1'b1, 1'b1, "R8");
    drive(1'b1, 1'b0);
    push(5'd0, 1'b1, 1'b0, "R8");
    drive(1'b1, 1'b0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #2;
    push(5'd0, 1'b1, 1'b0, "R1");
    drive(1'b0, 1'b0);
    push(5'd0, 1'b1, 1'b0, "R1");
    drive(1'b1, 1'b0);

    run_row(7'h00, 5'd0,  1'b0, 0, 0, 1'b0, "R2");
    run_row(7'h20, 5'd1,  1'b0, 0, 0, 1'b0, "R2");
    run_row(7'h60, 5'd0,  1'b0, 0, 0, 1'b0, "R2");
    run_row(7'h0D, 5'd2,  1'b0, 0, 0, 1'b0, "R3");
    run_row(7'h12, 5'd0,  1'b0, 0, 0, 1'b0, "R5");
    run_row(7'h7F, 5'd3,  1'b0, 0, 0, 1'b0, "R4");
    run_row(7'h40, 5'd0,  1'b1, 0, 0, 1'b0, "R6");
    run_row(7'h05, 5'd2,  1'b1, 0, 0, 1'b0, "R6");
    run_row(7'h5F, 5'd31, 1'b0, 0, 0, 1'b0, "R7");
    run_row(7'h03, 5'd0,  1'b0, 1, 0, 1'b0, "R10");
    run_row(7'h05, 5'd4,  1'b0, 0, 7, 1'b0, "R9");
    run_row(7'h09, 5'd1,  1'b1, 0, 0, 1'b1, "R9");

    repeat (3) @(posedge clk_i);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      failures++;
      $display("FAIL %s actual=unchecked expected=font %0d", e.tag, e.font);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule